// File: doc/BRIEF.md
# DRAM Timing Parameter Scaler

This block turns a set of nominal DRAM timing values, given in clock cycles, into a shortened set for a fast row-access mode. Four unsigned fixed-point factors control the scaling: one for activate-to-column delay, one for activate-to-precharge, one for write recovery and one for the four-activate window. Each scaled value is rounded up to a whole cycle.

Some outputs are not scaled directly. The same-subarray row cycle is built from the two scaled activate delays. The write-related gaps are built from CAS write latency, burst length and the scaled write recovery time. A start pulse makes the block capture its inputs. One shared multiplier then works through the scaled terms one per cycle. A final cycle forms the sums, loads every output register and raises `done`. The results stay in the output registers until the next accepted start.

Top module: `dram_timing_scaler`

## Requirements
- R1: While reset is high, and on the first cycle after it, `busy`, `done`, `err` and all nine timing outputs read zero.
- R2: A high `start` while `busy` is low is accepted. `busy` is high from the next cycle, `done` and `err` are low from the next cycle, and the results appear with `done` high and `busy` low exactly 7 cycles after the accepting edge. A `start` seen while `busy` is high has no effect.
- R3: All inputs are sampled on the accepting edge. Changes to the inputs after that edge do not affect the results.
- R4: Factors are 9-bit unsigned with 8 fraction bits, so 256 means 1.0. A scaled term is ceil(value × factor / 256). An output that exceeds 255 saturates at 255.
- R5: `out_act_rd` and `out_act_wr` are the activate-to-read and activate-to-write defaults scaled by `fac_rcd`.
- R6: `out_act_pre` and `out_act_prea` are the activate-to-precharge and activate-to-precharge-all defaults scaled by `fac_ras`.
- R7: `out_act_act` is the saturated sum of the unsaturated scaled activate-to-read term and the unsaturated scaled activate-to-precharge-all term.
- R8: `out_wr_pre` is saturate(cwl + burst_len + ceil(wr_recov × fac_wr / 256)).
- R9: `out_wra_act` is the R8 sum plus `pre_time`, saturated.
- R10: `out_sib_gap` is saturate(cwl + burst_len + ceil(wr_recov × fac_wr / 512)).
- R11: `out_faw` is the four-activate-window default scaled by `fac_faw`.
- R12: `err` is high together with `done` when the scaled activate-to-read term or the scaled activate-to-precharge-all term is zero. Otherwise `err` is low.
- R13: While `busy` is low and no start is accepted, every output keeps its value, whatever the inputs do.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a computation (taken only when idle) |
| dflt_act_rd | input | 8 | Nominal activate-to-read cycles |
| dflt_act_wr | input | 8 | Nominal activate-to-write cycles |
| dflt_act_pre | input | 8 | Nominal activate-to-precharge cycles |
| dflt_act_prea | input | 8 | Nominal activate-to-precharge-all cycles |
| dflt_faw | input | 8 | Nominal four-activate window |
| cwl | input | 8 | CAS write latency |
| burst_len | input | 8 | Burst length in cycles |
| wr_recov | input | 8 | Nominal write recovery cycles |
| pre_time | input | 8 | Precharge period |
| fac_rcd | input | 9 | Activate-to-column factor, Q1.8 |
| fac_ras | input | 9 | Activate-to-precharge factor, Q1.8 |
| fac_wr | input | 9 | Write recovery factor, Q1.8 |
| fac_faw | input | 9 | Four-activate window factor, Q1.8 |
| busy | output | 1 | Computation in progress |
| done | output | 1 | Results valid |
| err | output | 1 | A scaled activate term came out as zero |
| out_act_rd | output | 8 | Scaled activate-to-read |
| out_act_wr | output | 8 | Scaled activate-to-write |
| out_act_pre | output | 8 | Scaled activate-to-precharge |
| out_act_prea | output | 8 | Scaled activate-to-precharge-all |
| out_act_act | output | 8 | Same-subarray row cycle |
| out_wr_pre | output | 8 | Write-to-precharge and write-to-precharge-all gap |
| out_wra_act | output | 8 | Write-with-autoprecharge to activate gap |
| out_sib_gap | output | 8 | Gap after a write to a sibling subarray |
| out_faw | output | 8 | Scaled four-activate window |

## Verification
The bench builds the block with its default widths: 8-bit cycle counts and 9-bit factors with 8 fraction bits.

- **Extremes.** With these widths, a factor of 511 applied to a value of 255 reaches the largest product. This drives the scaled terms past 255 and pushes both derived sums into saturation.
- **Zero and rounding.** Zero factors and single-cycle values test the zero-result error flag and the round-up of tiny products. Unity factors must return the defaults unchanged.
- **Randomised runs.** Random operands cover the space in between.
- **Snapshot and hold.** The bench pulses `start` in the middle of a computation, with different inputs present, to check that the snapshot holds. It also changes the inputs while the block is idle to check that the outputs hold.

// File: rtl/tsc_pkg.sv
package tsc_pkg;

    localparam int CYC_W   = 8;
    localparam int FRAC_W  = 8;
    localparam int FAC_W   = FRAC_W + 1;
    localparam int PROD_W  = CYC_W + FAC_W;
    localparam int RAW_W   = CYC_W + 1;
    localparam int SUM_W   = CYC_W + 4;
    localparam int NSTEP   = 6;
    localparam int CYC_MAX = (1 << CYC_W) - 1;

    typedef enum logic [1:0] {
        PH_IDLE,
        PH_SCALE,
        PH_MERGE
    } phase_e;

    // order of the multiplier passes
    typedef enum logic [2:0] {
        SEL_RD   = 3'd0,
        SEL_WR   = 3'd1,
        SEL_PRE  = 3'd2,
        SEL_PREA = 3'd3,
        SEL_WREC = 3'd4,
        SEL_FAW  = 3'd5
    } step_e;

    typedef struct packed {
        logic [CYC_W-1:0] act_rd;
        logic [CYC_W-1:0] act_wr;
        logic [CYC_W-1:0] act_pre;
        logic [CYC_W-1:0] act_prea;
        logic [CYC_W-1:0] faw;
        logic [CYC_W-1:0] cwl;
        logic [CYC_W-1:0] blen;
        logic [CYC_W-1:0] wrec;
        logic [CYC_W-1:0] rp;
        logic [FAC_W-1:0] f_rcd;
        logic [FAC_W-1:0] f_ras;
        logic [FAC_W-1:0] f_wr;
        logic [FAC_W-1:0] f_faw;
    } cfg_t;

    typedef struct packed {
        logic [RAW_W-1:0] rd;
        logic [RAW_W-1:0] wr;
        logic [RAW_W-1:0] pre;
        logic [RAW_W-1:0] prea;
        logic [RAW_W-1:0] wrec_full;
        logic [CYC_W-1:0] wrec_half;
        logic [RAW_W-1:0] faw;
    } raw_t;

    typedef struct packed {
        logic [CYC_W-1:0] act_rd;
        logic [CYC_W-1:0] act_wr;
        logic [CYC_W-1:0] act_pre;
        logic [CYC_W-1:0] act_prea;
        logic [CYC_W-1:0] act_act;
        logic [CYC_W-1:0] wr_pre;
        logic [CYC_W-1:0] wra_act;
        logic [CYC_W-1:0] sib_gap;
        logic [CYC_W-1:0] faw;
    } res_t;

    function automatic logic [CYC_W-1:0] clamp(input logic [SUM_W-1:0] v);
        if (v > SUM_W'(CYC_MAX)) begin
            return CYC_W'(CYC_MAX);
        end
        return CYC_W'(v);
    endfunction

endpackage

// File: rtl/tsc_ceil_mul.sv
module tsc_ceil_mul
    import tsc_pkg::*;
(
    input  logic [CYC_W-1:0] val,
    input  logic [FAC_W-1:0] fac,
    output logic [RAW_W-1:0] full,
    output logic [CYC_W-1:0] half
);

    localparam logic [PROD_W-1:0] RND_FULL = PROD_W'((1 << FRAC_W) - 1);
    localparam logic [PROD_W-1:0] RND_HALF = PROD_W'((1 << (FRAC_W + 1)) - 1);

    logic [PROD_W-1:0] prod;
    logic [PROD_W-1:0] up_full;
    logic [PROD_W-1:0] up_half;

    always_comb begin
        prod    = PROD_W'(val) * PROD_W'(fac);
        up_full = prod + RND_FULL;
        up_half = prod + RND_HALF;
        full    = RAW_W'(up_full >> FRAC_W);
        half    = CYC_W'(up_half >> (FRAC_W + 1));
    end

endmodule

// File: rtl/tsc_seq.sv
module tsc_seq
    import tsc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  start,
    output logic  launch,
    output logic  scale_en,
    output logic  merge_en,
    output logic  busy,
    output step_e step
);

    phase_e phase;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase <= PH_IDLE;
            step  <= SEL_RD;
        end else begin
            case (phase)
                PH_IDLE: begin
                    if (start) begin
                        phase <= PH_SCALE;
                        step  <= SEL_RD;
                    end
                end
                PH_SCALE: begin
                    if (step == step_e'(NSTEP - 1)) begin
                        phase <= PH_MERGE;
                    end else begin
                        step <= step_e'(step + 3'd1);
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    always_comb begin
        launch   = (phase == PH_IDLE) && start;
        scale_en = (phase == PH_SCALE);
        merge_en = (phase == PH_MERGE);
        busy     = (phase != PH_IDLE);
    end

endmodule

// File: rtl/tsc_combine.sv
module tsc_combine
    import tsc_pkg::*;
(
    input  raw_t             raw,
    input  logic [CYC_W-1:0] cwl,
    input  logic [CYC_W-1:0] blen,
    input  logic [CYC_W-1:0] rp,
    output res_t             res,
    output logic             zero_hit
);

    logic [SUM_W-1:0] wr_base;
    logic [SUM_W-1:0] wr_full_sum;

    always_comb begin
        wr_base     = SUM_W'(cwl) + SUM_W'(blen);
        wr_full_sum = wr_base + SUM_W'(raw.wrec_full);

        res.act_rd   = clamp(SUM_W'(raw.rd));
        res.act_wr   = clamp(SUM_W'(raw.wr));
        res.act_pre  = clamp(SUM_W'(raw.pre));
        res.act_prea = clamp(SUM_W'(raw.prea));
        res.act_act  = clamp(SUM_W'(raw.rd) + SUM_W'(raw.prea));
        res.wr_pre   = clamp(wr_full_sum);
        res.wra_act  = clamp(wr_full_sum + SUM_W'(rp));
        res.sib_gap  = clamp(wr_base + SUM_W'(raw.wrec_half));
        res.faw      = clamp(SUM_W'(raw.faw));

        zero_hit = (raw.rd == '0) || (raw.prea == '0);
    end

endmodule

// File: rtl/dram_timing_scaler.sv
module dram_timing_scaler
    import tsc_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [CYC_W-1:0] dflt_act_rd,
    input  logic [CYC_W-1:0] dflt_act_wr,
    input  logic [CYC_W-1:0] dflt_act_pre,
    input  logic [CYC_W-1:0] dflt_act_prea,
    input  logic [CYC_W-1:0] dflt_faw,
    input  logic [CYC_W-1:0] cwl,
    input  logic [CYC_W-1:0] burst_len,
    input  logic [CYC_W-1:0] wr_recov,
    input  logic [CYC_W-1:0] pre_time,
    input  logic [FAC_W-1:0] fac_rcd,
    input  logic [FAC_W-1:0] fac_ras,
    input  logic [FAC_W-1:0] fac_wr,
    input  logic [FAC_W-1:0] fac_faw,
    output logic             busy,
    output logic             done,
    output logic             err,
    output logic [CYC_W-1:0] out_act_rd,
    output logic [CYC_W-1:0] out_act_wr,
    output logic [CYC_W-1:0] out_act_pre,
    output logic [CYC_W-1:0] out_act_prea,
    output logic [CYC_W-1:0] out_act_act,
    output logic [CYC_W-1:0] out_wr_pre,
    output logic [CYC_W-1:0] out_wra_act,
    output logic [CYC_W-1:0] out_sib_gap,
    output logic [CYC_W-1:0] out_faw
);

    logic  launch;
    logic  scale_en;
    logic  merge_en;
    step_e step;

    cfg_t incoming;
    cfg_t snap;
    raw_t raw_q;
    res_t res_q;
    res_t res_d;
    logic zero_hit;

    logic [CYC_W-1:0] op_val;
    logic [FAC_W-1:0] op_fac;
    logic [RAW_W-1:0] mul_full;
    logic [CYC_W-1:0] mul_half;

    tsc_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .launch   (launch),
        .scale_en (scale_en),
        .merge_en (merge_en),
        .busy     (busy),
        .step     (step)
    );

    always_comb begin
        incoming.act_rd   = dflt_act_rd;
        incoming.act_wr   = dflt_act_wr;
        incoming.act_pre  = dflt_act_pre;
        incoming.act_prea = dflt_act_prea;
        incoming.faw      = dflt_faw;
        incoming.cwl      = cwl;
        incoming.blen     = burst_len;
        incoming.wrec     = wr_recov;
        incoming.rp       = pre_time;
        incoming.f_rcd    = fac_rcd;
        incoming.f_ras    = fac_ras;
        incoming.f_wr     = fac_wr;
        incoming.f_faw    = fac_faw;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            snap <= '0;
        end else if (launch) begin
            snap <= incoming;
        end
    end

    // operand select for the shared multiplier
    always_comb begin
        case (step)
            SEL_RD:   begin op_val = snap.act_rd;   op_fac = snap.f_rcd; end
            SEL_WR:   begin op_val = snap.act_wr;   op_fac = snap.f_rcd; end
            SEL_PRE:  begin op_val = snap.act_pre;  op_fac = snap.f_ras; end
            SEL_PREA: begin op_val = snap.act_prea; op_fac = snap.f_ras; end
            SEL_WREC: begin op_val = snap.wrec;     op_fac = snap.f_wr;  end
            default:  begin op_val = snap.faw;      op_fac = snap.f_faw; end
        endcase
    end

    tsc_ceil_mul u_mul (
        .val  (op_val),
        .fac  (op_fac),
        .full (mul_full),
        .half (mul_half)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            raw_q <= '0;
        end else if (scale_en) begin
            case (step)
                SEL_RD:   raw_q.rd   <= mul_full;
                SEL_WR:   raw_q.wr   <= mul_full;
                SEL_PRE:  raw_q.pre  <= mul_full;
                SEL_PREA: raw_q.prea <= mul_full;
                SEL_WREC: begin
                    raw_q.wrec_full <= mul_full;
                    raw_q.wrec_half <= mul_half;
                end
                default:  raw_q.faw  <= mul_full;
            endcase
        end
    end

    tsc_combine u_comb (
        .raw      (raw_q),
        .cwl      (snap.cwl),
        .blen     (snap.blen),
        .rp       (snap.rp),
        .res      (res_d),
        .zero_hit (zero_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            done  <= 1'b0;
            err   <= 1'b0;
        end else if (launch) begin
            done <= 1'b0;
            err  <= 1'b0;
        end else if (merge_en) begin
            res_q <= res_d;
            done  <= 1'b1;
            err   <= zero_hit;
        end
    end

    always_comb begin
        out_act_rd   = res_q.act_rd;
        out_act_wr   = res_q.act_wr;
        out_act_pre  = res_q.act_pre;
        out_act_prea = res_q.act_prea;
        out_act_act  = res_q.act_act;
        out_wr_pre   = res_q.wr_pre;
        out_wra_act  = res_q.wra_act;
        out_sib_gap  = res_q.sib_gap;
        out_faw      = res_q.faw;
    end

endmodule

// File: rtl/dram_timing_scaler_chk.sv
module dram_timing_scaler_chk
    import tsc_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic             busy,
    input logic             done,
    input logic             err,
    input logic [CYC_W-1:0] out_act_rd,
    input logic [CYC_W-1:0] out_act_prea,
    input logic [CYC_W-1:0] out_act_act,
    input logic [CYC_W-1:0] out_wr_pre,
    input logic [CYC_W-1:0] out_wra_act,
    input logic [CYC_W-1:0] out_sib_gap,
    input logic [CYC_W-1:0] out_faw
);

    p_busy_done_excl_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_launch_r2: assert property (@(posedge clk) disable iff (rst)
        (start && !busy) |=> (busy && !done && !err));

    p_finish_r2: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> done);

    p_hold_r13: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start) |=> ($stable(out_act_act) && $stable(out_wr_pre)
                               && $stable(out_sib_gap) && $stable(out_faw)
                               && $stable(done)));

    p_row_cycle_r7: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_act_act >= out_act_rd) && (out_act_act >= out_act_prea));

    p_wra_ge_r9: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_wra_act >= out_wr_pre));

    p_sib_le_r10: assert property (@(posedge clk) disable iff (rst)
        done |-> (out_sib_gap <= out_wr_pre));

    p_err_done_r12: assert property (@(posedge clk) disable iff (rst)
        err |-> done);

endmodule

bind dram_timing_scaler dram_timing_scaler_chk i_chk (
    .clk          (clk),
    .rst          (rst),
    .start        (start),
    .busy         (busy),
    .done         (done),
    .err          (err),
    .out_act_rd   (out_act_rd),
    .out_act_prea (out_act_prea),
    .out_act_act  (out_act_act),
    .out_wr_pre   (out_wr_pre),
    .out_wra_act  (out_wra_act),
    .out_sib_gap  (out_sib_gap),
    .out_faw      (out_faw)
);

// File: tb/test_dram_timing_scaler.sv
`timescale 1ns/1ps
module test_dram_timing_scaler;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic start = 1'b0;
    logic [7:0] d_rd, d_wr, d_pre, d_prea, d_faw, d_cwl, d_bl, d_wrec, d_rp;
    logic [8:0] f_rcd, f_ras, f_wr, f_faw;
    logic busy, done, err;
    logic [7:0] o_rd, o_wr, o_pre, o_prea, o_rc, o_wrpre, o_wra, o_sib, o_faw;

    int n_checks = 0;
    int n_fail = 0;
    bit chk_en = 1'b0;
    bit finished = 1'b0;

    always #10 clk = ~clk;

    dram_timing_scaler i_dram_timing_scaler (
        .clk(clk), .rst(rst), .start(start),
        .dflt_act_rd(d_rd), .dflt_act_wr(d_wr), .dflt_act_pre(d_pre),
        .dflt_act_prea(d_prea), .dflt_faw(d_faw), .cwl(d_cwl),
        .burst_len(d_bl), .wr_recov(d_wrec), .pre_time(d_rp),
        .fac_rcd(f_rcd), .fac_ras(f_ras), .fac_wr(f_wr), .fac_faw(f_faw),
        .busy(busy), .done(done), .err(err),
        .out_act_rd(o_rd), .out_act_wr(o_wr), .out_act_pre(o_pre),
        .out_act_prea(o_prea), .out_act_act(o_rc), .out_wr_pre(o_wrpre),
        .out_wra_act(o_wra), .out_sib_gap(o_sib), .out_faw(o_faw)
    );

    // behavioural reference model
    bit m_busy, m_done, m_err;
    int m_cnt;
    int s_rd, s_wr, s_pre, s_prea, s_faw, s_cwl, s_bl, s_wrec, s_rp;
    int s_frcd, s_fras, s_fwr, s_ffaw;
    int e_rd, e_wr, e_pre, e_prea, e_rc, e_wrpre, e_wra, e_sib, e_faw;

    function automatic int up_scale(int v, int f, int sh);
        return (v * f + (1 << sh) - 1) >> sh;
    endfunction

    function automatic int lim(int v);
        return (v > 255) ? 255 : v;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_busy <= 0; m_done <= 0; m_err <= 0; m_cnt <= 0;
            e_rd <= 0; e_wr <= 0; e_pre <= 0; e_prea <= 0; e_rc <= 0;
            e_wrpre <= 0; e_wra <= 0; e_sib <= 0; e_faw <= 0;
        end else if (!m_busy && start) begin
            m_busy <= 1; m_done <= 0; m_err <= 0; m_cnt <= 0;
            s_rd <= d_rd; s_wr <= d_wr; s_pre <= d_pre; s_prea <= d_prea;
            s_faw <= d_faw; s_cwl <= d_cwl; s_bl <= d_bl; s_wrec <= d_wrec;
            s_rp <= d_rp; s_frcd <= f_rcd; s_fras <= f_ras; s_fwr <= f_wr;
            s_ffaw <= f_faw;
        end else if (m_busy) begin
            if (m_cnt == 6) begin
                int rd_raw, prea_raw, wf, wh;
                rd_raw   = up_scale(s_rd, s_frcd, 8);
                prea_raw = up_scale(s_prea, s_fras, 8);
                wf       = up_scale(s_wrec, s_fwr, 8);
                wh       = up_scale(s_wrec, s_fwr, 9);
                m_busy  <= 0;
                m_done  <= 1;
                m_err   <= (rd_raw == 0) || (prea_raw == 0);
                e_rd    <= lim(rd_raw);
                e_wr    <= lim(up_scale(s_wr, s_frcd, 8));
                e_pre   <= lim(up_scale(s_pre, s_fras, 8));
                e_prea  <= lim(prea_raw);
                e_rc    <= lim(rd_raw + prea_raw);
                e_wrpre <= lim(s_cwl + s_bl + wf);
                e_wra   <= lim(s_cwl + s_bl + wf + s_rp);
                e_sib   <= lim(s_cwl + s_bl + wh);
                e_faw   <= lim(up_scale(s_faw, s_ffaw, 8));
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(string req, string what, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
        end
    endtask

    // compared on every clock, away from the rising edge
    always @(negedge clk) begin
        if (chk_en && !finished) begin
            check("R2", "busy", busy, m_busy);
            check("R2", "done", done, m_done);
            check("R12", "err", err, m_err);
            check("R5", "act_rd", o_rd, e_rd);
            check("R5", "act_wr", o_wr, e_wr);
            check("R6", "act_pre", o_pre, e_pre);
            check("R6", "act_prea", o_prea, e_prea);
            check("R7", "act_act", o_rc, e_rc);
            check("R8", "wr_pre", o_wrpre, e_wrpre);
            check("R9", "wra_act", o_wra, e_wra);
            check("R10", "sib_gap", o_sib, e_sib);
            check("R11", "faw", o_faw, e_faw);
        end
    end

    task automatic set_cfg(int rd, int wr, int pre, int prea, int faw, int cw,
                           int bl, int wrec, int rp, int fr, int fa, int fw, int ff);
        d_rd = 8'(rd); d_wr = 8'(wr); d_pre = 8'(pre); d_prea = 8'(prea);
        d_faw = 8'(faw); d_cwl = 8'(cw); d_bl = 8'(bl); d_wrec = 8'(wrec);
        d_rp = 8'(rp); f_rcd = 9'(fr); f_ras = 9'(fa); f_wr = 9'(fw); f_faw = 9'(ff);
    endtask

    task automatic run_once();
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (9) @(negedge clk);
    endtask

    initial begin
        set_cfg(0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0);
        repeat (3) @(negedge clk);
        chk_en = 1'b1;              // R1: reset values compared here
        @(negedge clk) rst = 1'b0;
        @(negedge clk);
        check("R1", "done after reset", done, 0);

        // R4/R5: unity factors return the defaults
        set_cfg(14, 13, 33, 34, 20, 10, 4, 15, 14, 256, 256, 256, 256);
        run_once();
        check("R5", "unity act_rd", o_rd, 14);

        // typical reduction factors, ceiling rounding
        set_cfg(14, 13, 33, 34, 20, 10, 4, 15, 14, 154, 179, 128, 192);
        run_once();
        check("R8", "typical wr_pre", o_wrpre, 10 + 4 + 8);
        check("R10", "typical sib_gap", o_sib, 10 + 4 + 4);

        // saturation at the extreme
        set_cfg(255, 255, 255, 255, 255, 200, 100, 255, 255, 511, 511, 511, 511);
        run_once();
        check("R4", "saturated act_rd", o_rd, 255);
        check("R7", "saturated act_act", o_rc, 255);

        // zero factor raises the error flag
        set_cfg(14, 13, 33, 34, 20, 10, 4, 15, 14, 0, 179, 0, 192);
        run_once();
        check("R12", "zero rcd err", err, 1);
        set_cfg(14, 13, 33, 0, 20, 10, 4, 15, 14, 154, 179, 128, 192);
        run_once();
        check("R12", "zero prea err", err, 1);

        // tiny product rounds up
        set_cfg(1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1, 1);
        run_once();
        check("R4", "tiny round-up", o_rd, 1);
        check("R10", "tiny sib", o_sib, 3);

        // R2/R3: start during busy with other inputs is ignored
        set_cfg(20, 20, 40, 40, 30, 12, 8, 18, 16, 200, 220, 100, 180);
        @(negedge clk) start = 1'b1;
        @(negedge clk) start = 1'b0;
        @(negedge clk);
        set_cfg(99, 99, 99, 99, 99, 99, 99, 99, 99, 300, 300, 300, 300);
        start = 1'b1;
        @(negedge clk) start = 1'b0;
        repeat (8) @(negedge clk);
        check("R3", "snapshot act_rd", o_rd, (20 * 200 + 255) / 256);

        // R13: idle input changes do not move outputs
        set_cfg(7, 7, 7, 7, 7, 7, 7, 7, 7, 7, 7, 7, 7);
        repeat (5) @(negedge clk);
        check("R13", "idle hold act_rd", o_rd, (20 * 200 + 255) / 256);

        // randomised runs
        for (int k = 0; k < 40; k++) begin
            set_cfg($urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 255),
                    $urandom_range(0, 255), $urandom_range(0, 255), $urandom_range(0, 40),
                    $urandom_range(0, 16), $urandom_range(0, 255), $urandom_range(0, 255),
                    $urandom_range(0, 511), $urandom_range(0, 511), $urandom_range(0, 511),
                    $urandom_range(0, 511));
            run_once();
        end

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            finished = 1'b1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule